// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This unit gives every CPU in a small cluster two inter-processor interrupt channels: a "cross" channel that any CPU can raise on any set of CPUs, and a "self" channel that a CPU raises on itself. Software reaches the unit through a register port with several request lanes. Every request carries the index of the CPU that issues it, so that CPU's own channel state is the one addressed by acknowledge, mask and event operations.

Each CPU sees a level interrupt line whenever one of its channels is pending and unmasked. When the CPU reads its event register it gets a type/number word that names the channel being delivered. That read masks the delivered channel automatically, so software acknowledges the channel and then unmasks it when it is ready for the next one. A per-CPU input tells the unit that a hardware interrupt is waiting for that CPU. While it is set, the hardware source outranks both channels and the unit offers nothing on that CPU's event read.

Top module: `ipi_unit`

## Requirements
- R1: After reset no channel is pending, both channels of every CPU are masked, every `irq_out` bit is 0, and an event read returns 0.
- R2: A write to the send register (select 0) with bit k set, for k below the CPU count, raises the cross channel of CPU k. One write can target several CPUs.
- R3: A send write with bit 31 set raises the self channel of the issuing CPU only.
- R4: A write to the acknowledge register (select 1) clears the issuing CPU's cross flag when bit 0 is set and its self flag when bit 31 is set. Other CPUs are not affected.
- R5: Select 2 sets mask bits and select 3 clears them, with bit 0 for cross and bit 31 for self, on the issuing CPU. When a set and a clear reach the same mask bit in one cycle, the mask ends up set.
- R6: An event read (select 4) returns, one cycle later on the same lane's `rsp_data`, the word 0x0004_0001 for cross or 0x0004_0002 for self (type 4 in bits 31:16, number in bits 15:0). It returns 0 when no channel can be delivered. A lane that issued no event read returns 0.
- R7: When both channels are pending and unmasked, cross is delivered first.
- R8: An event read that delivers a channel sets that channel's mask and leaves its pending flag set until it is acknowledged.
- R9: While `hw_pend` is set for a CPU, its event read returns 0 and changes no mask.
- R10: A send and an acknowledge that hit the same pending flag in the same cycle leave the flag set.
- R11: `irq_out[c]` is 1 exactly when CPU c has a channel that is pending and unmasked.
- R12: A write to select 4 has no effect. A read of any other select returns 0 and masks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NP | Request strobe, one bit per lane |
| req_write | input | NP | 1 = write, 0 = read, per lane |
| req_cpu | input | NP*CW | Issuing CPU index, per lane |
| req_sel | input | NP*3 | Register select, per lane |
| req_wdata | input | NP*32 | Write data, per lane |
| hw_pend | input | NC | A hardware interrupt is waiting for this CPU |
| rsp_data | output | NP*32 | Registered event-read response, per lane |
| irq_out | output | NC | Interrupt line to each CPU |

## Verification
A wrong pending or mask bit shows on `irq_out` in the cycle after the write that caused it, because the line is derived directly from registered state. A wrong channel choice or a missing auto-mask shows on the next event read: the response word either names the wrong channel or repeats when it should return 0. The bench keeps its own model of every flag and compares both outputs on every clock, so any divergence is reported within one cycle of the operation that introduced it.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W     = 32;
    localparam int SEL_W      = 3;
    localparam int BIT_CROSS  = 0;
    localparam int BIT_SELF   = 31;

    localparam logic [15:0] EV_TYPE_IPI = 16'd4;
    localparam logic [15:0] EV_NUM_CROSS = 16'd1;
    localparam logic [15:0] EV_NUM_SELF  = 16'd2;

    typedef enum logic [SEL_W-1:0] {
        REG_SEND     = 3'd0,
        REG_ACK      = 3'd1,
        REG_MASK_ON  = 3'd2,
        REG_MASK_OFF = 3'd3,
        REG_EVENT    = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_NONE  = 2'd0,
        CH_CROSS = 2'd1,
        CH_SELF  = 2'd2
    } chan_e;

    // Per-CPU action bundle produced by one request lane.
    typedef struct packed {
        logic raise_cross;
        logic raise_self;
        logic clr_cross;
        logic clr_self;
        logic mon_cross;
        logic mon_self;
        logic moff_cross;
        logic moff_self;
        logic take;
    } cpu_act_t;

    function automatic logic [WORD_W-1:0] event_word(input chan_e ch);
        logic [WORD_W-1:0] w;
        case (ch)
            CH_CROSS: w = {EV_TYPE_IPI, EV_NUM_CROSS};
            CH_SELF:  w = {EV_TYPE_IPI, EV_NUM_SELF};
            default:  w = '0;
        endcase
        return w;
    endfunction

    function automatic cpu_act_t merge_act(input cpu_act_t a, input cpu_act_t b);
        return a | b;
    endfunction

endpackage

// File: rtl/ipi_lane_decode.sv
module ipi_lane_decode
    import ipi_pkg::*;
#(
    parameter int NC = 4,
    parameter int CW = 2
) (
    input  logic                 valid,
    input  logic                 write,
    input  logic [CW-1:0]        cpu,
    input  logic [SEL_W-1:0]     sel,
    input  logic [WORD_W-1:0]    wdata,
    output cpu_act_t             act [NC]
);

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    logic wr_send, wr_ack, wr_on, wr_off, rd_evt;
    assign wr_send = valid &&  write && (sel_e == REG_SEND);
    assign wr_ack  = valid &&  write && (sel_e == REG_ACK);
    assign wr_on   = valid &&  write && (sel_e == REG_MASK_ON);
    assign wr_off  = valid &&  write && (sel_e == REG_MASK_OFF);
    assign rd_evt  = valid && !write && (sel_e == REG_EVENT);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar c = 0; c < NC; c++) begin : g_cpu
        logic own;
        assign own = (int'(cpu) == c);

        assign act[c].raise_cross = wr_send && wdata[c];
        assign act[c].raise_self  = wr_send && own && wdata[BIT_SELF];
        assign act[c].clr_cross   = wr_ack  && own && wdata[BIT_CROSS];
        assign act[c].clr_self    = wr_ack  && own && wdata[BIT_SELF];
        assign act[c].mon_cross   = wr_on   && own && wdata[BIT_CROSS];
        assign act[c].mon_self    = wr_on   && own && wdata[BIT_SELF];
        assign act[c].moff_cross  = wr_off  && own && wdata[BIT_CROSS];
        assign act[c].moff_self   = wr_off  && own && wdata[BIT_SELF];
        assign act[c].take        = rd_evt  && own;
    end

endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
    import ipi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_act_t act,
    input  logic     hw_busy,
    output logic     pend_cross,
    output logic     pend_self,
    output logic     mask_cross,
    output logic     mask_self,
    output chan_e    offer,
    output logic     irq
);

    logic live_cross, live_self;
    assign live_cross = pend_cross && !mask_cross;
    assign live_self  = pend_self  && !mask_self;
    assign irq        = live_cross || live_self;

    // Fixed priority: a waiting hardware line, then cross, then self.
    always_comb begin
        if (hw_busy)         offer = CH_NONE;
        else if (live_cross) offer = CH_CROSS;
        else if (live_self)  offer = CH_SELF;
        else                 offer = CH_NONE;
    end

    logic auto_cross, auto_self;
    assign auto_cross = act.take && (offer == CH_CROSS);
    assign auto_self  = act.take && (offer == CH_SELF);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cross <= 1'b0;
            pend_self  <= 1'b0;
            mask_cross <= 1'b1;
            mask_self  <= 1'b1;
        end else begin
            pend_cross <= act.raise_cross || (pend_cross && !act.clr_cross);
            pend_self  <= act.raise_self  || (pend_self  && !act.clr_self);
            mask_cross <= act.mon_cross || auto_cross || (mask_cross && !act.moff_cross);
            mask_self  <= act.mon_self  || auto_self  || (mask_self  && !act.moff_self);
        end
    end

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NC = 4,
    parameter int NP = 2,
    parameter int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        req_valid,
    input  logic [NP-1:0]        req_write,
    input  logic [NP*CW-1:0]     req_cpu,
    input  logic [NP*SEL_W-1:0]  req_sel,
    input  logic [NP*WORD_W-1:0] req_wdata,
    input  logic [NC-1:0]        hw_pend,
    output logic [NP*WORD_W-1:0] rsp_data,
    output logic [NC-1:0]        irq_out
);

    cpu_act_t lane_act [NP][NC];
    cpu_act_t cpu_act  [NC];
    chan_e    offer    [NC];

    logic [NC-1:0] pend_cross_v, pend_self_v, mask_cross_v, mask_self_v;

    for (genvar l = 0; l < NP; l++) begin : g_lane
        ipi_lane_decode #(.NC(NC), .CW(CW)) u_dec (
            .valid (req_valid[l]),
            .write (req_write[l]),
            .cpu   (req_cpu[l*CW +: CW]),
            .sel   (req_sel[l*SEL_W +: SEL_W]),
            .wdata (req_wdata[l*WORD_W +: WORD_W]),
            .act   (lane_act[l])
        );
    end

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            cpu_act[c] = '0;
            for (int l = 0; l < NP; l++) begin
                cpu_act[c] = merge_act(cpu_act[c], lane_act[l][c]);
            end
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_slot
        ipi_cpu_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .act        (cpu_act[c]),
            .hw_busy    (hw_pend[c]),
            .pend_cross (pend_cross_v[c]),
            .pend_self  (pend_self_v[c]),
            .mask_cross (mask_cross_v[c]),
            .mask_self  (mask_self_v[c]),
            .offer      (offer[c]),
            .irq        (irq_out[c])
        );
    end

    for (genvar l = 0; l < NP; l++) begin : g_rsp
        logic [CW-1:0]     who;
        logic              evt_rd;
        logic [WORD_W-1:0] rsp_n, rsp_q;

        assign who    = req_cpu[l*CW +: CW];
        assign evt_rd = req_valid[l] && !req_write[l] &&
                        (reg_sel_e'(req_sel[l*SEL_W +: SEL_W]) == REG_EVENT) &&
                        (int'(who) < NC);

        always_comb begin
            rsp_n = '0;
            if (evt_rd) rsp_n = event_word(offer[who]);
        end

        always_ff @(posedge clk) begin
            if (rst) rsp_q <= '0;
            else     rsp_q <= rsp_n;
        end

        assign rsp_data[l*WORD_W +: WORD_W] = rsp_q;
    end

endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
    parameter int NC = 4,
    parameter int NP = 2,
    parameter int CW = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NP-1:0]        req_valid,
    input logic [NP-1:0]        req_write,
    input logic [NP*CW-1:0]     req_cpu,
    input logic [NP*3-1:0]      req_sel,
    input logic [NP*32-1:0]     req_wdata,
    input logic [NC-1:0]        hw_pend,
    input logic [NP*32-1:0]     rsp_data,
    input logic [NC-1:0]        irq_out,
    input logic [NC-1:0]        pend_cross,
    input logic [NC-1:0]        pend_self,
    input logic [NC-1:0]        mask_cross
);

    logic [NC-1:0] send_c, ack_c, mon_c;
    always_comb begin
        send_c = '0;
        ack_c  = '0;
        mon_c  = '0;
        for (int l = 0; l < NP; l++) begin
            for (int c = 0; c < NC; c++) begin
                if (req_valid[l] && req_write[l] && req_sel[l*3 +: 3] == 3'd0 && req_wdata[l*32 + c])
                    send_c[c] = 1'b1;
                if (req_valid[l] && req_write[l] && req_sel[l*3 +: 3] == 3'd1 &&
                    int'(req_cpu[l*CW +: CW]) == c && req_wdata[l*32])
                    ack_c[c] = 1'b1;
                if (req_valid[l] && req_write[l] && req_sel[l*3 +: 3] == 3'd2 &&
                    int'(req_cpu[l*CW +: CW]) == c && req_wdata[l*32])
                    mon_c[c] = 1'b1;
            end
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pend_cross == '0 && pend_self == '0 && mask_cross == '1 && irq_out == '0)); // R1

    for (genvar c = 0; c < NC; c++) begin : g_c
        AST_SEND_RAISES: assert property (@(posedge clk) disable iff (rst)
            send_c[c] |=> pend_cross[c]); // R2
        AST_SEND_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
            (send_c[c] && ack_c[c]) |=> pend_cross[c]); // R10
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack_c[c] && !send_c[c]) |=> !pend_cross[c]); // R4
        AST_MASK_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            mon_c[c] |=> mask_cross[c]); // R5
        AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
            irq_out[c] |-> (pend_cross[c] || pend_self[c])); // R11
    end

    for (genvar l = 0; l < NP; l++) begin : g_l
        logic [CW-1:0] cpu_q;
        logic [NC-1:0] hw_q;
        logic [31:0]   rsp;
        assign rsp = rsp_data[l*32 +: 32];
        always_ff @(posedge clk) begin
            cpu_q <= req_cpu[l*CW +: CW];
            hw_q  <= hw_pend;
        end
        AST_EVENT_FORM: assert property (@(posedge clk) disable iff (rst)
            (rsp == 32'h0 || rsp == 32'h0004_0001 || rsp == 32'h0004_0002)); // R6
        AST_AUTO_MASK: assert property (@(posedge clk) disable iff (rst)
            (rsp == 32'h0004_0001 && int'(cpu_q) < NC) |-> mask_cross[cpu_q]); // R8
        AST_HW_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            (rsp != 32'h0 && int'(cpu_q) < NC) |-> !hw_q[cpu_q]); // R9
    end

endmodule

bind ipi_unit ipi_unit_chk #(.NC(NC), .NP(NP), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_cpu    (req_cpu),
    .req_sel    (req_sel),
    .req_wdata  (req_wdata),
    .hw_pend    (hw_pend),
    .rsp_data   (rsp_data),
    .irq_out    (irq_out),
    .pend_cross (pend_cross_v),
    .pend_self  (pend_self_v),
    .mask_cross (mask_cross_v)
);

// File: tb/ipi_unit_test.sv
module ipi_unit_test;

    localparam int NC = 4;
    localparam int NP = 2;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          l_valid [NP];
    logic          l_write [NP];
    logic [CW-1:0] l_cpu   [NP];
    logic [2:0]    l_sel   [NP];
    logic [31:0]   l_data  [NP];
    logic [NC-1:0] hw_pend;

    logic [NP-1:0]    req_valid, req_write;
    logic [NP*CW-1:0] req_cpu;
    logic [NP*3-1:0]  req_sel;
    logic [NP*32-1:0] req_wdata;
    logic [NP*32-1:0] rsp_data;
    logic [NC-1:0]    irq_out;

    always_comb begin
        for (int l = 0; l < NP; l++) begin
            req_valid[l]          = l_valid[l];
            req_write[l]          = l_write[l];
            req_cpu[l*CW +: CW]   = l_cpu[l];
            req_sel[l*3 +: 3]     = l_sel[l];
            req_wdata[l*32 +: 32] = l_data[l];
        end
    end

    ipi_unit #(.NC(NC), .NP(NP)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_cpu(req_cpu),
        .req_sel(req_sel), .req_wdata(req_wdata), .hw_pend(hw_pend),
        .rsp_data(rsp_data), .irq_out(irq_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference model.
    bit m_pc [NC], m_ps [NC], m_mc [NC], m_ms [NC];
    logic [31:0] m_rsp [NP];

    always @(posedge clk) begin
        bit sc, ss, ac, as_, onc, ons, offc, offs, tk;
        if (rst) begin
            for (int c = 0; c < NC; c++) begin
                m_pc[c] = 0; m_ps[c] = 0; m_mc[c] = 1; m_ms[c] = 1;
            end
            for (int l = 0; l < NP; l++) m_rsp[l] = 0;
        end else begin
            for (int l = 0; l < NP; l++) begin
                m_rsp[l] = 0;
                if (l_valid[l] && !l_write[l] && l_sel[l] == 3'd4 && !hw_pend[l_cpu[l]]) begin
                    if (m_pc[l_cpu[l]] && !m_mc[l_cpu[l]])      m_rsp[l] = 32'h0004_0001;
                    else if (m_ps[l_cpu[l]] && !m_ms[l_cpu[l]]) m_rsp[l] = 32'h0004_0002;
                end
            end
            for (int c = 0; c < NC; c++) begin
                sc = 0; ss = 0; ac = 0; as_ = 0; onc = 0; ons = 0; offc = 0; offs = 0; tk = 0;
                for (int l = 0; l < NP; l++) begin
                    if (l_valid[l] && l_write[l] && l_sel[l] == 3'd0 && l_data[l][c]) sc = 1;
                    if (l_valid[l] && int'(l_cpu[l]) == c) begin
                        if (l_write[l]) begin
                            case (l_sel[l])
                                3'd0: if (l_data[l][31]) ss = 1;
                                3'd1: begin if (l_data[l][0]) ac = 1; if (l_data[l][31]) as_ = 1; end
                                3'd2: begin if (l_data[l][0]) onc = 1; if (l_data[l][31]) ons = 1; end
                                3'd3: begin if (l_data[l][0]) offc = 1; if (l_data[l][31]) offs = 1; end
                                default: ;
                            endcase
                        end else if (l_sel[l] == 3'd4 && !hw_pend[c]) tk = 1;
                    end
                end
                if (tk && m_pc[c] && !m_mc[c])                      onc = 1;
                else if (tk && m_ps[c] && !m_ms[c])                 ons = 1;
                m_pc[c] = sc || (m_pc[c] && !ac);
                m_ps[c] = ss || (m_ps[c] && !as_);
                m_mc[c] = onc || (m_mc[c] && !offc);
                m_ms[c] = ons || (m_ms[c] && !offs);
            end
        end
    end

    // Clock-by-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [NC-1:0] m_irq;
            for (int c = 0; c < NC; c++) m_irq[c] = (m_pc[c] && !m_mc[c]) || (m_ps[c] && !m_ms[c]);
            checks++;
            if (irq_out !== m_irq) begin
                errors++;
                $display("FAIL R11 model irq_out actual=%b expected=%b", irq_out, m_irq);
            end
            for (int l = 0; l < NP; l++) begin
                checks++;
                if (rsp_data[l*32 +: 32] !== m_rsp[l]) begin
                    errors++;
                    $display("FAIL R6 model lane %0d rsp actual=%h expected=%h", l, rsp_data[l*32 +: 32], m_rsp[l]);
                end
            end
        end
    end

    task automatic clear_lanes();
        for (int l = 0; l < NP; l++) begin
            l_valid[l] = 0; l_write[l] = 0; l_cpu[l] = '0; l_sel[l] = '0; l_data[l] = '0;
        end
    endtask

    task automatic drive(input int l, input bit wr, input int cpu, input int sel, input logic [31:0] d);
        l_valid[l] = 1; l_write[l] = wr; l_cpu[l] = CW'(cpu); l_sel[l] = 3'(sel); l_data[l] = d;
    endtask

    task automatic step();
        @(negedge clk);
        clear_lanes();
    endtask

    task automatic chk_irq(input logic [NC-1:0] exp, input string tag);
        checks++;
        if (irq_out !== exp) begin
            errors++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    task automatic chk_rsp(input int l, input logic [31:0] exp, input string tag);
        checks++;
        if (rsp_data[l*32 +: 32] !== exp) begin
            errors++;
            $display("FAIL %s lane %0d rsp actual=%h expected=%h", tag, l, rsp_data[l*32 +: 32], exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            done = 1;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_lanes();
        hw_pend = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_irq(4'b0000, "R1");
        drive(0, 0, 0, 4, 0); step(); chk_rsp(0, 32'h0, "R1");

        // Cross channel to CPUs 1 and 2, both still masked.
        drive(0, 1, 0, 0, 32'h6); step(); chk_irq(4'b0000, "R5");
        drive(0, 1, 1, 3, 32'h1); step(); chk_irq(4'b0010, "R2");
        drive(0, 0, 1, 4, 0); step();
        chk_rsp(0, 32'h0004_0001, "R6"); chk_irq(4'b0000, "R8");
        drive(0, 0, 1, 4, 0); step(); chk_rsp(0, 32'h0, "R8");
        drive(0, 1, 1, 3, 32'h1); step(); chk_irq(4'b0010, "R8");
        drive(0, 1, 1, 1, 32'h1); step(); chk_irq(4'b0000, "R4");

        // CPU 2 still pending; an ack from CPU 1 must not touch it.
        drive(0, 1, 2, 3, 32'h1); step(); chk_irq(4'b0100, "R2");
        drive(0, 1, 1, 1, 32'h1); step(); chk_irq(4'b0100, "R4");

        // Hardware line outranks the channels.
        hw_pend = 4'b0100;
        drive(0, 0, 2, 4, 0); step();
        chk_rsp(0, 32'h0, "R9"); chk_irq(4'b0100, "R9");
        hw_pend = '0;
        drive(0, 0, 2, 4, 0); step();
        chk_rsp(0, 32'h0004_0001, "R9"); chk_irq(4'b0000, "R8");

        // Self and cross on CPU 3: cross first.
        drive(0, 1, 3, 0, 32'h8000_0008); step(); chk_irq(4'b0000, "R3");
        drive(0, 1, 3, 3, 32'h8000_0001); step(); chk_irq(4'b1000, "R3");
        drive(0, 0, 3, 4, 0); step(); chk_rsp(0, 32'h0004_0001, "R7");
        drive(0, 0, 3, 4, 0); step(); chk_rsp(0, 32'h0004_0002, "R7");
        drive(0, 0, 3, 4, 0); step(); chk_rsp(0, 32'h0, "R8");
        chk_irq(4'b0000, "R8");

        // Send and ack colliding on CPU 0's cross flag.
        drive(0, 1, 0, 3, 32'h1); step(); chk_irq(4'b0000, "R11");
        drive(0, 1, 1, 0, 32'h1); drive(1, 1, 0, 1, 32'h1); step();
        chk_irq(4'b0001, "R10");

        // Mask set and clear in the same cycle.
        drive(0, 1, 0, 2, 32'h1); drive(1, 1, 0, 3, 32'h1); step();
        chk_irq(4'b0000, "R5");

        // Writes to the event select and reads of other selects.
        drive(0, 1, 0, 3, 32'h1); step(); chk_irq(4'b0001, "R5");
        drive(0, 1, 0, 4, 32'hFFFF_FFFF); step(); chk_irq(4'b0001, "R12");
        drive(0, 0, 0, 0, 0); step();
        chk_rsp(0, 32'h0, "R12"); chk_irq(4'b0001, "R12");
        drive(1, 0, 0, 4, 0); step(); chk_rsp(1, 32'h0004_0001, "R6");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule